// File: doc/BRIEF.md
# PLL Configuration Word Calculator

This block turns two numbers into the setting for a display-link PLL. The first number is a reference clock frequency in kHz. The second is the bit rate wanted on each data lane, in kbps. The block returns a 16-bit PLL configuration word and a 6-bit divider field for the low-power escape clock. It works sequentially.

The pre-divider is found by a search that advances one step per cycle. The multiplier and the achieved rate come from a shared restoring divider that needs several cycles per result. The range code depends on the rate that is actually achieved, not on the rate requested.

The control side is a plain start/busy/done handshake. A `start` pulse seen while the block is idle latches both operands. `busy` stays high until the results are ready. `done` then pulses for one cycle, and the results stay unchanged until the next accepted start. There is no back-pressure on the result: the output registers hold their values, so the consumer may read them at any time after `done`. The reference frequency must be nonzero.

Top module: `pll_word_calc`

## Requirements
- R1: After reset, `busy`, `done` and `mul_sat` are 0, and `cfg_word` and `lp_div` are 0.
- R2: The pre-divider D starts at 1 and increases by one while ref_khz >= 5000*(D+1), stopping at 31. D is placed in `cfg_word[12:8]`, and it is never 0 when `done` pulses.
- R3: The multiplier M is ceil(lane_kbps*D/ref_khz). It is placed in `cfg_word[7:0]`.
- R4: If the multiplier would exceed 255, `cfg_word[7:0]` is 255 and `mul_sat` is 1. Otherwise `mul_sat` is 0.
- R5: The achieved rate A is floor(ref_khz*M'/D), where M' is M with 0 treated as 1. The range code in `cfg_word[15:14]` is 3 if A >= 501000, else 2 if A >= 251000, else 1 if A >= 126000, else 0. `cfg_word[13]` is 0.
- R6: `lp_div` is (ceil(A/80000) - 1) mod 64. This keeps the low-power clock at or below 10 MHz.
- R7: `busy` is high from the cycle after an accepted `start` until the cycle in which `done` is high. `done` is high for exactly one cycle. While idle, `cfg_word`, `lp_div` and `mul_sat` do not change.
- R8: A `start` that arrives while `busy` is high is ignored. The results belong to the operands that were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; sampled only when idle |
| ref_khz | input | 18 | Reference clock frequency in kHz, nonzero |
| lane_kbps | input | 20 | Desired per-lane bit rate in kbps |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| cfg_word | output | 16 | {range[1:0], 0, divider[4:0], multiplier[7:0]} |
| lp_div | output | 6 | Low-power clock divider field |
| mul_sat | output | 1 | Multiplier saturated at 255 |

## Verification
The vector set moves the reference frequency in both directions across the 10 MHz step where the pre-divider goes from 1 to 2. It also uses a 200 MHz reference, where the divider search stops at the cap of 31. Further vectors give achieved rates that land exactly on the 126000, 251000 and 501000 thresholds, or just below one, so that a `>` written in place of `>=` is caught. Other vectors cover a ceiling division that is exact and one that is not, a zero lane rate that exercises the zero-multiplier rule, and a request that saturates the multiplier. Directed sequences then cover the handshake: a start issued while busy, the width of the done pulse, and whether the outputs hold while idle.

// File: rtl/pllw_pkg.sv
package pllw_pkg;
  localparam int unsigned FLOOR_KHZ = 5000;
  localparam int unsigned DIV_CAP   = 31;
  localparam int unsigned MUL_MAX   = 255;
  localparam int unsigned LP_SPAN   = 80000;
  localparam int unsigned N_BANDS   = 3;
  localparam int unsigned BAND_TH [N_BANDS] = '{126000, 251000, 501000};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_MUL,
    ST_RATE,
    ST_LP
  } calc_state_t;
endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int unsigned W = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quotient
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  shreg, rem, dsr, lat_dvd;
  logic [W:0]    rem_sh, diff;
  logic [CW-1:0] cnt;
  logic          run, fin_q, fits;

  always_comb begin
    rem_sh = {rem, shreg[W-1]};
    diff   = rem_sh - {1'b0, dsr};
    fits   = !diff[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      rem     <= '0;
      dsr     <= '0;
      lat_dvd <= '0;
      cnt     <= '0;
      run     <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go && !run) begin
        shreg   <= dividend;
        lat_dvd <= dividend;
        dsr     <= divisor;
        rem     <= '0;
        cnt     <= '0;
        run     <= 1'b1;
      end else if (run) begin
        shreg <= {shreg[W-2:0], fits};
        rem   <= fits ? diff[W-1:0] : rem_sh[W-1:0];
        cnt   <= cnt + 1'b1;
        if (cnt == CW'(W-1)) begin
          run   <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin      = fin_q;
  assign quotient = shreg;

  AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && dsr != '0) |->
      (({{W{1'b0}}, shreg} * {{W{1'b0}}, dsr} + {{W{1'b0}}, rem}) == {{W{1'b0}}, lat_dvd})
      && (rem < dsr)); // R3
endmodule

// File: rtl/pllw_band.sv
module pllw_band
  import pllw_pkg::*;
#(
  parameter int unsigned RW = 27
) (
  input  logic [RW-1:0] rate,
  output logic [1:0]    band
);
  always_comb begin
    band = '0;
    for (int i = 0; i < int'(N_BANDS); i++) begin
      if (32'(rate) >= BAND_TH[i]) band = 2'(i + 1);
    end
  end
endmodule

// File: rtl/pll_word_calc.sv
module pll_word_calc
  import pllw_pkg::*;
#(
  parameter int unsigned REF_W  = 18,
  parameter int unsigned RATE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REF_W-1:0]  ref_khz,
  input  logic [RATE_W-1:0] lane_kbps,
  output logic              busy,
  output logic              done,
  output logic [15:0]       cfg_word,
  output logic [5:0]        lp_div,
  output logic              mul_sat
);
  localparam int unsigned DIV_W = 5;
  localparam int unsigned MUL_W = 8;
  localparam int unsigned P1 = RATE_W + DIV_W;
  localparam int unsigned P2 = REF_W + MUL_W;
  localparam int unsigned DW = ((P1 > P2) ? P1 : P2) + 1;

  calc_state_t       state;
  logic [DW-1:0]     ref_x, des_x, thr, rate_q, dv_a, dv_b, dv_q;
  logic [DIV_W-1:0]  div_q;
  logic [MUL_W-1:0]  mul_q, mul_next, mul_eff;
  logic              ovf_q, ovf_next, dv_go, dv_fin, done_q;
  logic [1:0]        band;

  seq_divider #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(dv_go),
    .dividend(dv_a), .divisor(dv_b),
    .fin(dv_fin), .quotient(dv_q)
  );

  pllw_band #(.RW(DW)) u_band (.rate(rate_q), .band(band));

  always_comb begin
    if (dv_q > DW'(MUL_MAX)) begin
      mul_next = MUL_W'(MUL_MAX);
      ovf_next = 1'b1;
    end else begin
      mul_next = dv_q[MUL_W-1:0];
      ovf_next = 1'b0;
    end
    mul_eff = (mul_next == '0) ? MUL_W'(1) : mul_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ref_x    <= '0;
      des_x    <= '0;
      thr      <= '0;
      rate_q   <= '0;
      div_q    <= '0;
      mul_q    <= '0;
      ovf_q    <= 1'b0;
      dv_a     <= '0;
      dv_b     <= '0;
      dv_go    <= 1'b0;
      done_q   <= 1'b0;
      cfg_word <= '0;
      lp_div   <= '0;
      mul_sat  <= 1'b0;
    end else begin
      dv_go  <= 1'b0;
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          ref_x <= DW'(ref_khz);
          des_x <= DW'(lane_kbps);
          div_q <= DIV_W'(1);
          thr   <= DW'(2 * FLOOR_KHZ);
          state <= ST_SEARCH;
        end
        ST_SEARCH: begin
          if (ref_x >= thr && div_q != DIV_W'(DIV_CAP)) begin
            div_q <= div_q + 1'b1;
            thr   <= thr + DW'(FLOOR_KHZ);
          end else begin
            dv_a  <= des_x * DW'(div_q) + ref_x - DW'(1);
            dv_b  <= ref_x;
            dv_go <= 1'b1;
            state <= ST_MUL;
          end
        end
        ST_MUL: if (dv_fin) begin
          mul_q <= mul_next;
          ovf_q <= ovf_next;
          dv_a  <= ref_x * DW'(mul_eff);
          dv_b  <= DW'(div_q);
          dv_go <= 1'b1;
          state <= ST_RATE;
        end
        ST_RATE: if (dv_fin) begin
          rate_q <= dv_q;
          dv_a   <= dv_q + DW'(LP_SPAN - 1);
          dv_b   <= DW'(LP_SPAN);
          dv_go  <= 1'b1;
          state  <= ST_LP;
        end
        ST_LP: if (dv_fin) begin
          cfg_word <= {band, 1'b0, div_q, mul_q};
          lp_div   <= dv_q[5:0] - 6'd1;
          mul_sat  <= ovf_q;
          done_q   <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(cfg_word) && $stable(lp_div) && $stable(mul_sat))); // R7
  AST_SAT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    mul_sat |-> cfg_word[7:0] == 8'hFF); // R4
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cfg_word[12:8] != '0); // R2
  AST_SEARCH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEARCH && div_q == DIV_W'(DIV_CAP)) |=> state == ST_MUL); // R2
endmodule

// File: tb/test_pll_word_calc.sv
module test_pll_word_calc;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [17:0] rk;
    logic [19:0] lk;
    logic [15:0] word;
    logic [5:0]  lp;
    logic        sat;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{18'd24000,  20'd480000,  16'h8450, 6'd5,  1'b0},
    '{18'd27000,  20'd500000,  16'hC55D, 6'd6,  1'b0},
    '{18'd8000,   20'd100000,  16'h010D, 6'd1,  1'b0},
    '{18'd4000,   20'd1040000, 16'hC1FF, 6'd12, 1'b1},
    '{18'd9000,   20'd126000,  16'h410E, 6'd1,  1'b0},
    '{18'd5000,   20'd125000,  16'h0119, 6'd1,  1'b0},
    '{18'd1000,   20'd251000,  16'h81FB, 6'd3,  1'b0},
    '{18'd3000,   20'd501000,  16'hC1A7, 6'd6,  1'b0},
    '{18'd24000,  20'd0,       16'h0400, 6'd0,  1'b0},
    '{18'd10000,  20'd200000,  16'h4228, 6'd2,  1'b0},
    '{18'd9999,   20'd200000,  16'h4115, 6'd2,  1'b0},
    '{18'd65535,  20'd1000000, 16'hCDC7, 6'd12, 1'b0},
    '{18'd200000, 20'd100000,  16'h1F10, 6'd1,  1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [17:0] ref_khz = '0;
  logic [19:0] lane_kbps = '0;
  logic        busy, done, mul_sat;
  logic [15:0] cfg_word;
  logic [5:0]  lp_div;
  int n_chk = 0, n_bad = 0;

  pll_word_calc i_pll_word_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_khz(ref_khz),
    .lane_kbps(lane_kbps), .busy(busy), .done(done),
    .cfg_word(cfg_word), .lp_div(lp_div), .mul_sat(mul_sat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic pulse_start(input logic [17:0] r, input logic [19:0] l);
    @(negedge clk);
    ref_khz = r; lane_kbps = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 1000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R7 done timeout actual=0 expected=1");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check("R1 word", 32'(cfg_word), 0);
    check("R1 lp", 32'(lp_div), 0);
    check("R1 sat", 32'(mul_sat), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      pulse_start(VEC[i].rk, VEC[i].lk);
      wait_done();
      check("R2/R3/R5 word", 32'(cfg_word), 32'(VEC[i].word));
      check("R6 lp", 32'(lp_div), 32'(VEC[i].lp));
      check("R4 sat", 32'(mul_sat), 32'(VEC[i].sat));
    end

    // R7: busy after accept, one-cycle done, outputs held while idle
    pulse_start(18'd24000, 20'd480000);
    check("R7 busy after start", 32'(busy), 1);
    wait_done();
    check("R7 busy low at done", 32'(busy), 0);
    @(negedge clk);
    check("R7 done width", 32'(done), 0);
    ref_khz = 18'd8000; lane_kbps = 20'd100000;
    repeat (5) @(negedge clk);
    check("R7 idle hold word", 32'(cfg_word), 32'h8450);
    check("R7 idle hold lp", 32'(lp_div), 5);

    // R8: second start during busy is ignored
    pulse_start(18'd27000, 20'd500000);
    repeat (3) @(negedge clk);
    pulse_start(18'd8000, 20'd100000);
    wait_done();
    check("R8 word", 32'(cfg_word), 32'hC55D);
    check("R8 lp", 32'(lp_div), 6);
    repeat (4) @(negedge clk);
    check("R8 no second run", 32'(busy), 0);

    finish_run();
  end
endmodule